// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from a chain of identical 4-bit stages, each counting modulo 16 on the rising clock edge. Every stage can be preset from parallel data through an active-low load input. It also has two count enables: a broadcast enable shared by all stages and a carry-style enable that comes from the stage below. A terminal-count output marks the all-ones state whenever the carry-style enable of that stage is high, so the next stage advances on the same edge. With the default of two stages, the chain is an 8-bit counter.

A build-time parameter picks the clear style. In one variant an active-low clear acts at once, with no clock needed. In the other the clear is sampled on the rising edge and takes priority over loading and counting. The chain's terminal count is brought out so that wider counters can be built from several instances.

Top module: `presettable_counter_chain`

## Requirements
- R1: When counting from the all-ones value (0xFF for two stages), the next value is zero; the count sequence is binary modulo 2^(STAGES*STAGE_W).
- R2: With CLR_SYNC=0, a low on clr_n drives q_out to zero at once, without a clock edge, and keeps it at zero while low, whatever the other inputs do.
- R3: With CLR_SYNC=1, a low on clr_n leaves q_out unchanged until the next rising edge, which then sets q_out to zero even if load_n is low and both enables are high.
- R4: With clr_n high and load_n low, a rising edge copies din into q_out, whatever the enables are.
- R5: With clr_n and load_n high and both en_par and en_trk high, each rising edge adds one to q_out.
- R6: With clr_n and load_n high and either en_par or en_trk low, q_out holds its value across the edge.
- R7: tc_out is combinational. It is 1 exactly when q_out is all ones and en_trk is 1, it follows en_trk with no clock edge, and load_n has no effect on it.
- R8: Loading the all-ones value with en_trk high raises tc_out right after the load edge, with no counting step needed.
- R9: Stage k advances only on edges where every lower stage is all ones, so the chained counter steps through every value from 0 to 255 with none skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous by CLR_SYNC |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Count enable broadcast to all stages |
| en_trk | input | 1 | Carry-style count enable of the lowest stage, also gates tc_out |
| din | input | STAGES*STAGE_W | Parallel preset data |
| q_out | output | STAGES*STAGE_W | Counter value |
| tc_out | output | 1 | Terminal count of the top stage |

## Verification
The bench steps the chain through all 256 states. A design whose carry did not depend on the lower stage would skip or repeat values at each nibble boundary, and a bad wrap would leave 0xFF stuck or jump to a wrong value. It checks the clear in the middle of a cycle, where an asynchronous variant wired as synchronous would keep its old value, and a synchronous one wired as asynchronous would drop early. Loads are applied with all enable settings and combined with a clear, which catches a wrong priority order. It also checks tc_out directly after an all-ones load and while en_trk toggles between edges, which catches a terminal count that is registered or that ignores the enable.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
   // Clear style selector values for CLR_SYNC
   localparam bit CLR_IMMEDIATE = 1'b0;
   localparam bit CLR_ON_EDGE   = 1'b1;

   // Next-state selection in priority order below clear
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_LOAD  = 2'd1,
      ACT_COUNT = 2'd2
   } cnt_act_e;

   function automatic cnt_act_e pick_action(input logic load_n,
                                            input logic en_p,
                                            input logic en_t);
      if (!load_n)            return ACT_LOAD;
      else if (en_p && en_t)  return ACT_COUNT;
      else                    return ACT_HOLD;
   endfunction
endpackage

// File: rtl/cnt_stage.sv
module cnt_stage
   import cnt_pkg::*;
#(
   parameter int STAGE_W  = 4,
   parameter bit CLR_SYNC = CLR_IMMEDIATE
) (
   input  logic               clk,
   input  logic               clr_n,
   input  logic               load_n,
   input  logic               en_p,
   input  logic               en_t,
   input  logic [STAGE_W-1:0] din,
   output logic [STAGE_W-1:0] q,
   output logic               tc
);
   localparam logic [STAGE_W-1:0] ALL_ONES = {STAGE_W{1'b1}};

   initial begin
      assert (STAGE_W >= 1) else $error("cnt_stage: STAGE_W must be at least 1");
   end

   cnt_act_e           act;
   logic [STAGE_W-1:0] cnt_q;
   logic [STAGE_W-1:0] cnt_d;

   always_comb begin
      act = pick_action(load_n, en_p, en_t);
      unique case (act)
         ACT_LOAD:  cnt_d = din;
         ACT_COUNT: cnt_d = cnt_q + 1'b1;
         default:   cnt_d = cnt_q;
      endcase
   end

   generate
      if (CLR_SYNC == CLR_IMMEDIATE) begin : g_clr_async
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
         end

         // R2: the register reads zero while clear is held, edge by edge
         a_r2_async_clear: assert property (@(posedge clk) !clr_n |-> (cnt_q == '0));
      end else begin : g_clr_sync
         always_ff @(posedge clk) begin
            if (!clr_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
         end

         // R3: a sampled clear wins over load and count on the next edge
         a_r3_sync_clear: assert property (@(posedge clk) !clr_n |=> (cnt_q == '0));
      end
   endgenerate

   assign q  = cnt_q;
   assign tc = en_t && (cnt_q == ALL_ONES);

   // R4: load takes din regardless of enables
   a_r4_load: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> (q == $past(din)));
   // R5: enabled count steps by one (wrapping within the stage)
   a_r5_count: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && en_p && en_t) |=> (q == $past(q) + 1'b1));
   // R6: either enable low holds the value
   a_r6_hold: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/presettable_counter_chain.sv
module presettable_counter_chain
   import cnt_pkg::*;
#(
   parameter int STAGES   = 2,
   parameter int STAGE_W  = 4,
   parameter bit CLR_SYNC = CLR_IMMEDIATE
) (
   input  logic                        clk,
   input  logic                        clr_n,
   input  logic                        load_n,
   input  logic                        en_par,
   input  logic                        en_trk,
   input  logic [STAGES*STAGE_W-1:0]   din,
   output logic [STAGES*STAGE_W-1:0]   q_out,
   output logic                        tc_out
);
   localparam int TOTAL_W = STAGES * STAGE_W;
   localparam logic [TOTAL_W-1:0] FULL = {TOTAL_W{1'b1}};

   initial begin
      assert (STAGES >= 1) else $error("presettable_counter_chain: STAGES must be at least 1");
      assert (STAGE_W >= 1) else $error("presettable_counter_chain: STAGE_W must be at least 1");
   end

   // trickle chain: entry 0 is the external enable, entry i+1 is stage i's terminal count
   logic [STAGES:0] trk_chain;
   assign trk_chain[0] = en_trk;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         cnt_stage #(
            .STAGE_W  (STAGE_W),
            .CLR_SYNC (CLR_SYNC)
         ) u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_p   (en_par),
            .en_t   (trk_chain[i]),
            .din    (din[i*STAGE_W +: STAGE_W]),
            .q      (q_out[i*STAGE_W +: STAGE_W]),
            .tc     (trk_chain[i+1])
         );
      end
   endgenerate

   assign tc_out = trk_chain[STAGES];

   // R9: the whole chain steps by exactly one when counting
   a_r9_chain_step: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && en_par && en_trk) |=> (q_out == $past(q_out) + 1'b1));
   // R1: counting from all ones wraps to zero
   a_r1_wrap: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && en_par && en_trk && q_out == FULL) |=> (q_out == '0));
   // R7: terminal count only at all ones with the trickle enable high
   a_r7_tc: assert property (@(posedge clk) disable iff (!clr_n)
      tc_out |-> (en_trk && q_out == FULL));
endmodule

// File: tb/tb_presettable_counter_chain.sv
module tb_presettable_counter_chain;
   localparam int CLK_P = 10;
   localparam int W     = 8;

   logic         clk = 1'b0;
   logic         clr_n = 1'b0;
   logic         load_n = 1'b1;
   logic         en_par = 1'b0;
   logic         en_trk = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] q_a, q_s;
   logic         tc_a, tc_s;

   int n_checks = 0;
   int n_fail   = 0;

   logic [W-1:0] exp_q_fifo[$];
   bit           exp_tc_fifo[$];
   string        tag_fifo[$];
   logic [W-1:0] model = '0;

   always #(CLK_P/2) clk = ~clk;

   presettable_counter_chain #(.STAGES(2), .STAGE_W(4), .CLR_SYNC(1'b0)) dut (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
      .din(din), .q_out(q_a), .tc_out(tc_a));

   presettable_counter_chain #(.STAGES(2), .STAGE_W(4), .CLR_SYNC(1'b1)) dut_sync (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
      .din(din), .q_out(q_s), .tc_out(tc_s));

   task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: apply one cycle of inputs and queue the expected post-edge result
   task automatic step(input logic c, input logic l, input logic ep, input logic et,
                       input logic [W-1:0] d, input string tag);
      @(negedge clk);
      clr_n = c; load_n = l; en_par = ep; en_trk = et; din = d;
      if (!c)            model = '0;
      else if (!l)       model = d;
      else if (ep && et) model = model + 1'b1;
      exp_q_fifo.push_back(model);
      exp_tc_fifo.push_back(et && (model == '1));
      tag_fifo.push_back(tag);
   endtask

   // monitor: compare both variants a quarter period after each edge
   always begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q_fifo.size() > 0) begin
         logic [W-1:0] eq;
         bit           et;
         string        tg;
         eq = exp_q_fifo.pop_front();
         et = exp_tc_fifo.pop_front();
         tg = tag_fifo.pop_front();
         check(q_a == eq, {tg, " async q"}, q_a, eq);
         check(q_s == eq, {tg, " sync q"}, q_s, eq);
         check(tc_a == et, {tg, " async tc"}, {7'd0, tc_a}, {7'd0, et});
         check(tc_s == et, {tg, " sync tc"}, {7'd0, tc_s}, {7'd0, et});
      end
   end

   initial begin
      #(CLK_P * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      // reset state (R2 / R3)
      step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R2 reset");
      step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R3 reset");
      // R4 loads under different enables
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, "R4 load en off");
      step(1'b1, 1'b0, 1'b1, 1'b1, 8'h11, "R4 load en on");
      // R6 hold variants
      step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R6 hold par low");
      step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R6 hold trk low");
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R6 hold both low");
      // R5 counting across a nibble carry
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h1D, "R4 preset");
      for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R5 count");
      // R8 immediate terminal count after an all-ones load
      step(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, "R8 load ff");
      step(1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, "R7 tc with load low");
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, "R7 tc gated by trk");
      // R7 tc follows en_trk between edges
      @(negedge clk);
      #(CLK_P/8);
      en_trk = 1'b1;
      #1;
      check(tc_a == 1'b1, "R7 tc rises with trk", {7'd0, tc_a}, 8'h01);
      en_trk = 1'b0;
      #1;
      check(tc_a == 1'b0, "R7 tc falls with trk", {7'd0, tc_a}, 8'h00);
      // R1 wrap
      step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1 wrap");
      // R9 full cascade sweep
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R4 zero");
      for (int i = 0; i < 256; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R9 sweep");
      // R3 clear beats load and count
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, "R4 preset a5");
      step(1'b0, 1'b0, 1'b1, 1'b1, 8'h77, "R3 clear priority");
      // R2 vs R3 mid-cycle clear
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, "R4 preset 5a");
      @(negedge clk);
      model = '0;
      exp_q_fifo.push_back(8'h00);
      exp_tc_fifo.push_back(1'b0);
      tag_fifo.push_back("R3 clear at edge");
      load_n = 1'b1;
      #(CLK_P/8);
      clr_n = 1'b0;
      #1;
      check(q_a == 8'h00, "R2 immediate clear", q_a, 8'h00);
      check(q_s == 8'h5A, "R3 waits for edge", q_s, 8'h5A);
      din = 8'hC3;
      load_n = 1'b0;
      #1;
      check(q_a == 8'h00, "R2 clear overrides load", q_a, 8'h00);
      load_n = 1'b1;
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R6 after clear");
      @(negedge clk);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule